// File: doc/BRIEF.md
# Down-Counting Timer Bank

A bank of independent down-counters reached through a single-cycle register port. Every channel holds a reload value, a running count, an underflow tally and a one-bit interrupt latch with its own mask. A channel counts only when the bank-wide run bit and its own run bit are both set. It counts only on cycles where the tick input is high. When the count has reached zero, the next tick reloads it, bumps the underflow tally and latches the interrupt.

The count cannot be read directly. A read of a channel's underflow register returns the tally and, in the same cycle, freezes a copy of the running count. Later reads of the channel's count register return that frozen copy. Software that wants a coherent pair therefore reads the underflow register first and the count register second. With a reload of all ones, the bitwise inverse of the count is a free-running up-count.

Top module: `dcnt_bank`

## Requirements
- R1: After reset the run bit, every channel's enable, count copy, tally, interrupt latch and mask read as zero. Every reload reads as all ones, the identity register reads the constant `REV_ID`, and `irq_o` is zero.
- R2: A channel's count changes only on a cycle where the bank run bit (offset 0x00, bit 0), its own enable bit and `cnt_tick_i` are all high.
- R3: While a channel's enable bit is clear, its count tracks its reload register. Once the enable is set, the count falls by one per qualifying tick, starting from the reload value.
- R4: A qualifying tick that finds the count at zero reloads it from the reload register, sets interrupt status bit 0 and adds one to the underflow tally.
- R5: A read of the underflow register copies the running count. The count register returns that copy and does not change until the next underflow-register read.
- R6: Writing 1 to bit 0 of the clear register drops status bit 0. An underflow in the same cycle wins, and the bit stays set.
- R7: A channel's `irq_o` bit is high exactly when its status bit 0 and mask bit 0 are both set.
- R8: The address map is as follows. Offset 0x00 is the run register and offset 0x10 is the identity register. Channel c occupies 0x20*(c+1), with these offsets inside the window:
  - +0x00: enable bit 0
  - +0x04: reload
  - +0x08: count copy
  - +0x0C: tally
  - +0x10: status bit 0
  - +0x14: clear
  - +0x18: mask bit 0

  Misaligned or unmapped reads, and reads of the clear register, return zero. Writes to the identity, count, tally and status registers are ignored.
- R9: Read data is registered. It shows the addressed value in the cycle after `reg_rd_i` is high and holds until the next read.
- R10: Channels are independent. Activity on one channel leaves another channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cnt_tick_i | input | 1 | Count qualifier for all channels |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CH | Per-channel interrupt |

## Verification
The bench builds the bank with its defaults: four channels, 32-bit counts and tallies, and an 8-bit address. This places the last window at 0xA0, which is one window past the highest channel, so it must decode as unmapped. Small reload values, including zero, make an underflow fall within a few ticks. A reload of zero underflows on every tick, which makes the collision of a clear with a new underflow easy to provoke on purpose. The full 32-bit width keeps the all-ones reset reload and the untouched-channel copy visible as exact values.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

   localparam int unsigned WIN_SHIFT = 5;

   typedef enum logic [2:0] {
      SUB_CFG    = 3'd0,
      SUB_RELOAD = 3'd1,
      SUB_CUR    = 3'd2,
      SUB_OVF    = 3'd3,
      SUB_STAT   = 3'd4,
      SUB_CLR    = 3'd5,
      SUB_MASK   = 3'd6,
      SUB_NONE   = 3'd7
   } sub_e;

   localparam logic [4:0] TOP_RUN_OFS = 5'h00;
   localparam logic [4:0] TOP_REV_OFS = 5'h10;

endpackage

// File: rtl/dcnt_decode.sv
module dcnt_decode
   import dcnt_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NUM_CH-1:0] ch_sel_o,
   output sub_e              sub_o,
   output logic              run_hit_o,
   output logic              rev_hit_o
);

   localparam int unsigned WIN_W = ADDR_W - WIN_SHIFT;

   logic [WIN_W-1:0] win;
   logic [2:0]       word;
   logic             aligned;

   assign win     = addr_i[ADDR_W-1:WIN_SHIFT];
   assign word    = addr_i[4:2];
   assign aligned = (addr_i[1:0] == 2'b00);
   assign sub_o   = sub_e'(word);

   assign run_hit_o = (win == '0) && (addr_i[4:0] == TOP_RUN_OFS);
   assign rev_hit_o = (win == '0) && (addr_i[4:0] == TOP_REV_OFS);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      assign ch_sel_o[c] = aligned && (word != 3'd7) && (win == WIN_W'(c + 1));
   end

endmodule

// File: rtl/dcnt_chan.sv
module dcnt_chan
   import dcnt_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned OVF_W = 32
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        glob_en_i,
   input  logic        tick_i,
   input  logic        sel_i,
   input  logic        wr_i,
   input  logic        rd_i,
   input  sub_e        sub_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o,
   output logic        irq_o
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("dcnt_chan: CNT_W must lie in 1..32");
   end
   if (OVF_W < 1 || OVF_W > 32) begin : g_bad_ovf
      $error("dcnt_chan: OVF_W must lie in 1..32");
   end

   logic             loc_en_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;
   logic [OVF_W-1:0] ovf_q;
   logic             stat_q;
   logic             mask_q;

   logic run, under, snap_cap;
   logic wr_cfg, wr_reload, wr_clr, wr_mask;
   logic [31:0] reload_rd, snap_rd, ovf_rd;

   assign run      = glob_en_i & loc_en_q & tick_i;
   assign under    = run & (cnt_q == '0);
   assign snap_cap = sel_i & rd_i & (sub_i == SUB_OVF);

   assign wr_cfg    = sel_i & wr_i & (sub_i == SUB_CFG);
   assign wr_reload = sel_i & wr_i & (sub_i == SUB_RELOAD);
   assign wr_clr    = sel_i & wr_i & (sub_i == SUB_CLR);
   assign wr_mask   = sel_i & wr_i & (sub_i == SUB_MASK);

   // readback extension: a zero-width replication is illegal, so pick by width
   if (CNT_W == 32) begin : g_cnt_full
      assign reload_rd = reload_q;
      assign snap_rd   = snap_q;
   end else begin : g_cnt_ext
      assign reload_rd = {{(32-CNT_W){1'b0}}, reload_q};
      assign snap_rd   = {{(32-CNT_W){1'b0}}, snap_q};
   end

   if (OVF_W == 32) begin : g_ovf_full
      assign ovf_rd = ovf_q;
   end else begin : g_ovf_ext
      assign ovf_rd = {{(32-OVF_W){1'b0}}, ovf_q};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         loc_en_q <= 1'b0;
         reload_q <= '1;
         mask_q   <= 1'b0;
      end else begin
         if (wr_cfg)    loc_en_q <= wdata_i[0];
         if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
         if (wr_mask)   mask_q   <= wdata_i[0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '1;
      end else if (!loc_en_q) begin
         cnt_q <= reload_q;
      end else if (run) begin
         cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q  <= '0;
         stat_q <= 1'b0;
         snap_q <= '0;
      end else begin
         if (under) ovf_q <= ovf_q + 1'b1;
         if (under) begin
            stat_q <= 1'b1;
         end else if (wr_clr && wdata_i[0]) begin
            stat_q <= 1'b0;
         end
         if (snap_cap) snap_q <= cnt_q;
      end
   end

   assign irq_o = stat_q & mask_q;

   always_comb begin
      rdata_o = '0;
      if (sel_i) begin
         case (sub_i)
            SUB_CFG:    rdata_o = {31'b0, loc_en_q};
            SUB_RELOAD: rdata_o = reload_rd;
            SUB_CUR:    rdata_o = snap_rd;
            SUB_OVF:    rdata_o = ovf_rd;
            SUB_STAT:   rdata_o = {31'b0, stat_q};
            SUB_MASK:   rdata_o = {31'b0, mask_q};
            default:    rdata_o = '0;
         endcase
      end
   end

   // R2: without a qualifying tick an enabled count holds
   a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (loc_en_q && !(glob_en_i && tick_i)) |=> $stable(cnt_q));

   // R3: a disabled channel tracks its reload value
   a_r3_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!loc_en_q) |=> (cnt_q == $past(reload_q)));

   // R3: an enabled channel steps down by one on a nonzero count
   a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4: a tick at zero bumps the tally and latches status
   a_r4_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (under) |=> (stat_q && ovf_q == $past(ovf_q) + 1'b1 && cnt_q == $past(reload_q)));

   // R5: the copy moves only on a tally read
   a_r5_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!snap_cap) |=> $stable(snap_q));

   // R6: a clear without a colliding underflow drops status
   a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clr && wdata_i[0] && !under) |=> !stat_q);

   // R7: a zero mask keeps the interrupt low
   a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mask_q) |-> !irq_o);

endmodule

// File: rtl/dcnt_bank.sv
module dcnt_bank
   import dcnt_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned OVF_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter logic [31:0] REV_ID = 32'h0003_0107
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cnt_tick_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [31:0]       reg_wdata_i,
   input  logic              reg_rd_i,
   output logic [31:0]       reg_rdata_o,
   output logic [NUM_CH-1:0] irq_o
);

   localparam int unsigned SPAN = (NUM_CH + 1) << WIN_SHIFT;

   if (NUM_CH < 1) begin : g_bad_nch
      $error("dcnt_bank: NUM_CH must be at least 1");
   end
   if (ADDR_W <= WIN_SHIFT || SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("dcnt_bank: ADDR_W too narrow for NUM_CH windows");
   end

   logic [NUM_CH-1:0]       ch_sel;
   sub_e                    sub;
   logic                    run_hit, rev_hit;
   logic                    glob_en_q;
   logic [NUM_CH-1:0][31:0] ch_rd;
   logic [31:0]             rd_mux;
   logic [31:0]             rdata_q;

   dcnt_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) decode_i (
      .addr_i    (reg_addr_i),
      .ch_sel_o  (ch_sel),
      .sub_o     (sub),
      .run_hit_o (run_hit),
      .rev_hit_o (rev_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         glob_en_q <= 1'b0;
      end else if (run_hit && reg_wr_i) begin
         glob_en_q <= reg_wdata_i[0];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dcnt_chan #(
         .CNT_W (CNT_W),
         .OVF_W (OVF_W)
      ) chan_i (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .glob_en_i (glob_en_q),
         .tick_i    (cnt_tick_i),
         .sel_i     (ch_sel[c]),
         .wr_i      (reg_wr_i),
         .rd_i      (reg_rd_i),
         .sub_i     (sub),
         .wdata_i   (reg_wdata_i),
         .rdata_o   (ch_rd[c]),
         .irq_o     (irq_o[c])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (run_hit) rd_mux = {31'b0, glob_en_q};
      if (rev_hit) rd_mux = REV_ID;
      for (int c = 0; c < NUM_CH; c++) begin
         rd_mux = rd_mux | ch_rd[c];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (reg_rd_i) begin
         rdata_q <= rd_mux;
      end
   end

   assign reg_rdata_o = rdata_q;

   // R8: the identity register always returns its constant
   a_r8_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rd_i && rev_hit) |=> (reg_rdata_o == REV_ID));

   // R9: read data holds between reads
   a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_rd_i) |=> $stable(reg_rdata_o));

   // R8: at most one window decodes at a time
   a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ch_sel, run_hit, rev_hit}));

endmodule

// File: tb/dcnt_bank_tb_top.sv
module dcnt_bank_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam int          NUM_CH     = 4;
   localparam int          ADDR_W     = 8;
   localparam logic [31:0] REV        = 32'h0003_0107;
   localparam int          WDOG_LIM   = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr = 1'b0;
   logic [31:0]       wdata = '0;
   logic              rd = 1'b0;
   logic [31:0]       rdata;
   logic [NUM_CH-1:0] irq;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_q = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dcnt_bank #(
      .NUM_CH (NUM_CH),
      .CNT_W  (32),
      .OVF_W  (32),
      .ADDR_W (ADDR_W),
      .REV_ID (REV)
   ) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cnt_tick_i  (tick),
      .reg_addr_i  (addr),
      .reg_wr_i    (wr),
      .reg_wdata_i (wdata),
      .reg_rd_i    (rd),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops one expected item per completed read
   always @(posedge clk) rd_q <= rd;
   always @(negedge clk) begin
      if (rd_q && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic t = 1'b0);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; tick = t;
      @(negedge clk);
      wr = 1'b0; tick = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a; rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      tick = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG_LIM) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {28'b0, irq}, 32'h0);
      rd_reg(8'h00, 32'h0,        "R1 run bit");
      rd_reg(8'h10, REV,          "R1 identity");
      rd_reg(8'h24, 32'hFFFFFFFF, "R1 reload0");
      rd_reg(8'h20, 32'h0,        "R1 enable0");
      rd_reg(8'h28, 32'h0,        "R1 copy0");
      rd_reg(8'h2C, 32'h0,        "R1 tally0");
      rd_reg(8'h30, 32'h0,        "R1 status0");
      rd_reg(8'h38, 32'h0,        "R1 mask0");

      // R8 map, read-only and unmapped
      wr_reg(8'h10, 32'hDEADBEEF);
      rd_reg(8'h10, REV, "R8 identity write ignored");
      wr_reg(8'h30, 32'h1);
      rd_reg(8'h30, 32'h0, "R8 status write ignored");
      wr_reg(8'h2C, 32'h1234);
      rd_reg(8'h2C, 32'h0, "R8 tally write ignored");
      rd_reg(8'h04, 32'h0, "R8 unmapped top");
      rd_reg(8'h3C, 32'h0, "R8 unmapped in window");
      rd_reg(8'hA0, 32'h0, "R8 window past last channel");
      rd_reg(8'h34, 32'h0, "R8 clear reads zero");
      rd_reg(8'h25, 32'h0, "R8 misaligned");

      // R2 bank run bit gates counting; R3 start from reload
      wr_reg(8'h24, 32'd10);
      wr_reg(8'h20, 32'h1);
      pulse(5);
      rd_reg(8'h2C, 32'h0,  "R2 tally with run off");
      rd_reg(8'h28, 32'd10, "R2 count frozen with run off");
      wr_reg(8'h00, 32'h1);
      rd_reg(8'h00, 32'h1,  "R8 run bit readback");
      pulse(3);
      rd_reg(8'h2C, 32'h0, "R3 tally");
      rd_reg(8'h28, 32'd7, "R3 count from reload");

      // R5 copy only refreshed by tally read
      pulse(2);
      rd_reg(8'h28, 32'd7, "R5 stale copy");
      rd_reg(8'h2C, 32'h0, "R5 tally");
      rd_reg(8'h28, 32'd5, "R5 fresh copy");

      // R4 underflow: 5 ticks to zero, sixth reloads
      pulse(6);
      rd_reg(8'h2C, 32'd1,  "R4 tally bumped");
      rd_reg(8'h28, 32'd10, "R4 reloaded");
      rd_reg(8'h30, 32'h1,  "R4 status set");
      chk("R7 masked irq", {28'b0, irq}, 32'h0);
      wr_reg(8'h38, 32'h1);
      chk("R7 unmasked irq", {28'b0, irq}, 32'h1);
      rd_reg(8'h38, 32'h1, "R7 mask readback");

      // R6 clear
      wr_reg(8'h34, 32'h1);
      chk("R6 irq after clear", {28'b0, irq}, 32'h0);
      rd_reg(8'h30, 32'h0, "R6 status cleared");

      // R3 disabled channel tracks reload
      wr_reg(8'h20, 32'h0);
      rd_reg(8'h2C, 32'd1,  "R3 tally kept");
      rd_reg(8'h28, 32'd10, "R3 disabled copy");

      // R6 collision on channel 1 (reload 0 underflows every tick)
      wr_reg(8'h44, 32'h0);
      wr_reg(8'h40, 32'h1);
      wr_reg(8'h58, 32'h1);
      wr_reg(8'h54, 32'h1, 1'b1);
      rd_reg(8'h50, 32'h1, "R6 underflow beats clear");
      chk("R7 ch1 irq", {28'b0, irq}, 32'h2);
      rd_reg(8'h4C, 32'h1, "R4 ch1 tally");
      wr_reg(8'h54, 32'h1);
      rd_reg(8'h50, 32'h0, "R6 ch1 cleared");
      chk("R7 ch1 irq low", {28'b0, irq}, 32'h0);

      // R10 untouched channel
      rd_reg(8'h6C, 32'h0,        "R10 ch2 tally");
      rd_reg(8'h68, 32'hFFFFFFFF, "R10 ch2 copy");
      rd_reg(8'h78, 32'h0,        "R10 ch2 mask");
      rd_reg(8'h2C, 32'd1,        "R10 ch0 tally unchanged");

      // R2 channel 3 with run off, then on
      wr_reg(8'h00, 32'h0);
      wr_reg(8'h84, 32'd5);
      wr_reg(8'h80, 32'h1);
      pulse(4);
      rd_reg(8'h8C, 32'h0,  "R2 ch3 tally run off");
      rd_reg(8'h88, 32'd5,  "R2 ch3 count run off");
      wr_reg(8'h00, 32'h1);
      pulse(5);
      rd_reg(8'h8C, 32'h0,  "R3 ch3 tally at zero");
      rd_reg(8'h88, 32'h0,  "R3 ch3 count at zero");
      pulse(1);
      rd_reg(8'h8C, 32'd1,  "R4 ch3 tally");
      rd_reg(8'h88, 32'd5,  "R4 ch3 reloaded");
      rd_reg(8'h90, 32'h1,  "R4 ch3 status");

      // R9 read data holds without a read
      @(negedge clk);
      held = rdata;
      chk("R9 last read value", held, 32'h1);
      repeat (3) @(negedge clk);
      chk("R9 hold between reads", rdata, held);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule